// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block collects six reset requests into a single active-high core reset and records which of them caused the most recent reset. The requests are power-on, an active-low external reset pin, a missing-clock timeout, an active-low comparator output, an active-low convert-start level and a watchdog overflow. Any request asserts the core reset at once, without waiting for a clock edge. Its release is retimed to the system clock through a short synchroniser chain. The pin path, which power-on also drives, adds a fixed stretch after the synchroniser.

Software uses a byte-wide write port and a byte-wide read port. Bits 5 and 6 have two meanings. A write to these bits enables the comparator source and the convert-start source. A read of these bits returns whether that source caused the last reset. The other flag bits are read-only. When the core leaves reset, exactly one cause flag is set. If several sources were active during the reset, a fixed priority picks the flag.

Top module: `reset_gather`

## Requirements
- R1: While `por_n_i` is low, `core_rst_o` is high. After `por_n_i` rises, reset is held for the synchroniser plus the pin stretch. On exit the status reads 0x02 (bit 1). Both source enables are cleared.
- R2: A low on `ext_rst_n_i` asserts `core_rst_o` without a clock edge. After the pin rises, the reset stays high for at least PIN_STRETCH (12) cycles. With the defaults it falls after the 14th rising edge. On exit the status reads 0x01 (bit 0).
- R3: A high `clk_lost_i` asserts `core_rst_o`. On exit the status reads 0x04 (bit 2).
- R4: Writing 1 to bit 5 enables the comparator source. A low `cmp_out_i` then asserts `core_rst_o` before any clock edge. On exit the status reads 0x20 (bit 5).
- R5: While the comparator source is disabled, a low `cmp_out_i` leaves `core_rst_o` low and leaves the status unchanged.
- R6: Writing 1 to bit 6 enables the convert-start source. The reset then stays high for as long as `cnv_n_i` is low. On exit the status reads 0x40 (bit 6).
- R7: A high `wdt_ovf_i` asserts `core_rst_o`. On exit the status reads 0x08 (bit 3).
- R8: On each exit from reset exactly one flag is set and all others are cleared. The flag goes to the highest-priority source active during that reset. The order is power-on, pin, clock loss, comparator, convert-start, watchdog. Flags change only on the clock edge that ends a reset.
- R9: The two source enables survive non-power-on resets. Power-on reset clears them.
- R10: Writes to bits 0 to 4 and bit 7 have no effect. Bits 4 and 7 always read 0. Writing 0 to bit 5 or bit 6 disables that source.
- R11: For every source except the pin, `core_rst_o` falls after the SYNC_STAGES-th (2) rising edge that follows the last request's release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n_i | input | 1 | Power-on request, active low, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| clk_lost_i | input | 1 | Missing-clock timeout request, active high |
| cmp_out_i | input | 1 | Comparator output, low requests reset when enabled |
| cnv_n_i | input | 1 | Convert-start level, low requests reset when enabled |
| wdt_ovf_i | input | 1 | Watchdog overflow request, active high |
| reg_wr_i | input | 1 | Write strobe for the enable bits |
| reg_wdata_i | input | 8 | Write data, bit 5 comparator enable, bit 6 convert-start enable |
| reg_rdata_o | output | 8 | Cause flags: bit0 pin, bit1 power-on, bit2 clock loss, bit3 watchdog, bit5 comparator, bit6 convert-start |
| core_rst_o | output | 1 | Core reset, active high |

## Verification
The bench builds the block with the defaults, PIN_STRETCH = 12 and SYNC_STAGES = 2. This lets it check the exact release edge of each path: the 14th edge after the pin rises, and the 2nd edge for every other source. Those two values also fix the edge on which each cause flag appears, so the bench can sample the status one cycle after release. Overlapping requests test the priority order. A power-on reset placed between enable writes shows which state survives which reset.

// File: rtl/reset_gather_pkg.sv
package reset_gather_pkg;

    localparam int NUM_SRC = 6;

    typedef enum logic [2:0] {
        SRC_POR = 3'd0,
        SRC_PIN = 3'd1,
        SRC_CLK = 3'd2,
        SRC_CMP = 3'd3,
        SRC_CNV = 3'd4,
        SRC_WDT = 3'd5
    } src_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic cnv;
        logic cmp;
    } src_en_t;

    localparam int FLAG_PIN_BIT = 0;
    localparam int FLAG_POR_BIT = 1;
    localparam int FLAG_CLK_BIT = 2;
    localparam int FLAG_WDT_BIT = 3;
    localparam int FLAG_CMP_BIT = 5;
    localparam int FLAG_CNV_BIT = 6;

    // Lowest index wins: index order is the priority order.
    function automatic src_vec_t pick_first(src_vec_t v);
        src_vec_t r;
        logic     found;
        r     = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (v[i] && !found) begin
                r[i]  = 1'b1;
                found = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] to_status(src_vec_t v);
        logic [7:0] b;
        b               = '0;
        b[FLAG_POR_BIT] = v[SRC_POR];
        b[FLAG_PIN_BIT] = v[SRC_PIN];
        b[FLAG_CLK_BIT] = v[SRC_CLK];
        b[FLAG_CMP_BIT] = v[SRC_CMP];
        b[FLAG_CNV_BIT] = v[SRC_CNV];
        b[FLAG_WDT_BIT] = v[SRC_WDT];
        return b;
    endfunction

endpackage

// File: rtl/rg_req_gate.sv
module rg_req_gate
    import reset_gather_pkg::*;
(
    input  logic     por_n_i,
    input  logic     ext_rst_n_i,
    input  logic     clk_lost_i,
    input  logic     cmp_out_i,
    input  logic     cnv_n_i,
    input  logic     wdt_ovf_i,
    input  src_en_t  en_i,
    output src_vec_t req_o
);

    always_comb begin
        req_o          = '0;
        req_o[SRC_POR] = !por_n_i;
        // Power-on also drives the pin path so its stretch applies and
        // the stretch counter leaves power-up in a known state.
        req_o[SRC_PIN] = !ext_rst_n_i || !por_n_i;
        req_o[SRC_CLK] = clk_lost_i;
        req_o[SRC_CMP] = en_i.cmp && !cmp_out_i;
        req_o[SRC_CNV] = en_i.cnv && !cnv_n_i;
        req_o[SRC_WDT] = wdt_ovf_i;
    end

endmodule

// File: rtl/rg_release.sv
module rg_release #(
    parameter int SYNC_STAGES = 2,
    parameter int EXTRA       = 0
) (
    input  logic clk,
    input  logic req_i,
    output logic hold_o
);

    localparam int CW = (EXTRA > 0) ? $clog2(EXTRA + 1) : 1;

    logic [SYNC_STAGES-1:0] sh_q;
    logic                   ext_busy;

    // Set at once by the request, released through the shift chain.
    always_ff @(posedge clk or posedge req_i) begin
        if (req_i) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[SYNC_STAGES-2:0], 1'b0};
        end
    end

    generate
        if (EXTRA > 0) begin : g_stretch
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or posedge req_i) begin
                if (req_i) begin
                    cnt_q <= CW'(EXTRA);
                end else if (!sh_q[SYNC_STAGES-1] && (cnt_q != '0)) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            assign ext_busy = (cnt_q != '0);
        end else begin : g_plain
            assign ext_busy = 1'b0;
        end
    endgenerate

    assign hold_o = sh_q[SYNC_STAGES-1] || ext_busy;

endmodule

// File: rtl/rg_status.sv
module rg_status
    import reset_gather_pkg::*;
(
    input  logic       clk,
    input  logic       por_n_i,
    input  src_vec_t   hold_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output src_en_t    en_o,
    output logic [7:0] rdata_o
);

    src_vec_t seen_q;
    src_vec_t cause_q;
    src_en_t  en_q;
    logic     unused_wdata;

    assign unused_wdata = ^{wdata_i[7], wdata_i[4:0]};

    always_ff @(posedge clk or negedge por_n_i) begin
        if (!por_n_i) begin
            seen_q  <= '0;
            cause_q <= '0;
        end else if (|hold_i) begin
            seen_q  <= seen_q | hold_i;
        end else if (|seen_q) begin
            cause_q <= pick_first(seen_q);
            seen_q  <= '0;
        end
    end

    always_ff @(posedge clk or negedge por_n_i) begin
        if (!por_n_i) begin
            en_q <= '0;
        end else if (wr_i) begin
            en_q.cmp <= wdata_i[FLAG_CMP_BIT];
            en_q.cnv <= wdata_i[FLAG_CNV_BIT];
        end
    end

    assign en_o    = en_q;
    assign rdata_o = to_status(cause_q);

endmodule

// File: rtl/reset_gather.sv
module reset_gather
    import reset_gather_pkg::*;
#(
    parameter int PIN_STRETCH = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n_i,
    input  logic       ext_rst_n_i,
    input  logic       clk_lost_i,
    input  logic       cmp_out_i,
    input  logic       cnv_n_i,
    input  logic       wdt_ovf_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       core_rst_o
);

    src_vec_t req_vec;
    src_vec_t hold_vec;
    src_en_t  en;
    logic     cmp_en;
    logic     cnv_en;

    rg_req_gate u_gate (
        .por_n_i     (por_n_i),
        .ext_rst_n_i (ext_rst_n_i),
        .clk_lost_i  (clk_lost_i),
        .cmp_out_i   (cmp_out_i),
        .cnv_n_i     (cnv_n_i),
        .wdt_ovf_i   (wdt_ovf_i),
        .en_i        (en),
        .req_o       (req_vec)
    );

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            localparam int EXTRA = (i == int'(SRC_PIN)) ? PIN_STRETCH : 0;
            rg_release #(
                .SYNC_STAGES (SYNC_STAGES),
                .EXTRA       (EXTRA)
            ) u_rel (
                .clk    (clk),
                .req_i  (req_vec[i]),
                .hold_o (hold_vec[i])
            );
        end
    endgenerate

    assign core_rst_o = |hold_vec;

    rg_status u_stat (
        .clk     (clk),
        .por_n_i (por_n_i),
        .hold_i  (hold_vec),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .en_o    (en),
        .rdata_o (reg_rdata_o)
    );

    assign cmp_en = en.cmp;
    assign cnv_en = en.cnv;

endmodule

// File: rtl/reset_gather_chk.sv
module reset_gather_chk #(
    parameter int PIN_STRETCH = 12
) (
    input logic       clk,
    input logic       por_n_i,
    input logic       ext_rst_n_i,
    input logic       clk_lost_i,
    input logic       cmp_out_i,
    input logic       cnv_n_i,
    input logic       wdt_ovf_i,
    input logic       cmp_en,
    input logic       cnv_en,
    input logic [7:0] reg_rdata_o,
    input logic       core_rst_o
);

    localparam int AW = $clog2(PIN_STRETCH + 2);

    logic [AW-1:0] since_q;
    logic          armed_q;

    always_ff @(posedge clk or negedge por_n_i) begin
        if (!por_n_i) begin
            since_q <= '0;
            armed_q <= 1'b0;
        end else if (!ext_rst_n_i) begin
            since_q <= '0;
            armed_q <= 1'b1;
        end else if (armed_q && (since_q < AW'(PIN_STRETCH))) begin
            since_q <= since_q + 1'b1;
        end else begin
            armed_q <= 1'b0;
        end
    end

    assert_pin_low_R2: assert property (@(posedge clk) disable iff (!por_n_i)
        !ext_rst_n_i |-> core_rst_o);

    assert_pin_stretch_R2: assert property (@(posedge clk) disable iff (!por_n_i)
        armed_q |-> core_rst_o);

    assert_clk_loss_R3: assert property (@(posedge clk) disable iff (!por_n_i)
        clk_lost_i |-> core_rst_o);

    assert_cmp_src_R4: assert property (@(posedge clk) disable iff (!por_n_i)
        (cmp_en && !cmp_out_i) |-> core_rst_o);

    assert_cnv_level_R6: assert property (@(posedge clk) disable iff (!por_n_i)
        (cnv_en && !cnv_n_i) |-> core_rst_o);

    assert_wdt_src_R7: assert property (@(posedge clk) disable iff (!por_n_i)
        wdt_ovf_i |-> core_rst_o);

    assert_one_flag_R8: assert property (@(posedge clk) disable iff (!por_n_i)
        $onehot0(reg_rdata_o));

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!por_n_i)
        (!core_rst_o && !$past(core_rst_o) && !$past(core_rst_o, 2))
        |-> $stable(reg_rdata_o));

endmodule

bind reset_gather reset_gather_chk #(.PIN_STRETCH(PIN_STRETCH)) u_chk (
    .clk         (clk),
    .por_n_i     (por_n_i),
    .ext_rst_n_i (ext_rst_n_i),
    .clk_lost_i  (clk_lost_i),
    .cmp_out_i   (cmp_out_i),
    .cnv_n_i     (cnv_n_i),
    .wdt_ovf_i   (wdt_ovf_i),
    .cmp_en      (cmp_en),
    .cnv_en      (cnv_en),
    .reg_rdata_o (reg_rdata_o),
    .core_rst_o  (core_rst_o)
);

// File: tb/reset_gather_bench.sv
`timescale 1ns/100ps
module reset_gather_bench;

    logic       clk = 1'b0;
    logic       por_n = 1'b1;
    logic       ext_n = 1'b1;
    logic       clk_lost = 1'b0;
    logic       cmp = 1'b1;
    logic       cnv_n = 1'b1;
    logic       wdt = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       core_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    reset_gather u_reset_gather (
        .clk         (clk),
        .por_n_i     (por_n),
        .ext_rst_n_i (ext_n),
        .clk_lost_i  (clk_lost),
        .cmp_out_i   (cmp),
        .cnv_n_i     (cnv_n),
        .wdt_ovf_i   (wdt),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .core_rst_o  (core_rst)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_en(input logic [7:0] b);
        wr    = 1'b1;
        wdata = b;
        step(1);
        wr    = 1'b0;
    endtask

    task automatic t_power_on;
        por_n = 1'b0;
        #0.5;
        chk("R1 reset during power-on", {7'd0, core_rst}, 8'h01);
        step(2);
        por_n = 1'b1;
        step(13);
        chk("R1 still held in stretch", {7'd0, core_rst}, 8'h01);
        step(1);
        chk("R1 released", {7'd0, core_rst}, 8'h00);
        step(1);
        chk("R1 power-on flag", rdata, 8'h02);
    endtask

    task automatic t_pin;
        ext_n = 1'b0;
        #0.5;
        chk("R2 async assert", {7'd0, core_rst}, 8'h01);
        step(3);
        ext_n = 1'b1;
        step(13);
        chk("R2 held 13 edges after release", {7'd0, core_rst}, 8'h01);
        step(1);
        chk("R2 released after 14th edge", {7'd0, core_rst}, 8'h00);
        step(1);
        chk("R2 pin flag", rdata, 8'h01);
    endtask

    task automatic t_clk_loss;
        clk_lost = 1'b1;
        #0.5;
        chk("R3 assert", {7'd0, core_rst}, 8'h01);
        step(3);
        clk_lost = 1'b0;
        step(1);
        chk("R11 held after 1st edge", {7'd0, core_rst}, 8'h01);
        step(1);
        chk("R11 released after 2nd edge", {7'd0, core_rst}, 8'h00);
        step(1);
        chk("R3 clock-loss flag", rdata, 8'h04);
    endtask

    task automatic t_cmp_disabled(input logic [7:0] prev);
        cmp = 1'b0;
        step(4);
        chk("R5 no reset when disabled", {7'd0, core_rst}, 8'h00);
        chk("R5 status unchanged", rdata, prev);
        cmp = 1'b1;
        step(1);
    endtask

    task automatic t_cmp;
        write_en(8'h20);
        cmp = 1'b0;
        #0.5;
        chk("R4 async assert", {7'd0, core_rst}, 8'h01);
        step(3);
        cmp = 1'b1;
        step(2);
        chk("R4 released", {7'd0, core_rst}, 8'h00);
        step(1);
        chk("R4 comparator flag", rdata, 8'h20);
    endtask

    task automatic t_cnv;
        write_en(8'h40);
        cnv_n = 1'b0;
        #0.5;
        chk("R6 assert", {7'd0, core_rst}, 8'h01);
        step(6);
        chk("R6 level held", {7'd0, core_rst}, 8'h01);
        cnv_n = 1'b1;
        step(2);
        chk("R6 released", {7'd0, core_rst}, 8'h00);
        step(1);
        chk("R6 convert-start flag", rdata, 8'h40);
        write_en(8'h00);
    endtask

    task automatic t_wdt(input logic [7:0] exp_flag);
        wdt = 1'b1;
        #0.5;
        chk("R7 assert", {7'd0, core_rst}, 8'h01);
        step(1);
        wdt = 1'b0;
        step(1);
        chk("R11 watchdog held", {7'd0, core_rst}, 8'h01);
        step(1);
        chk("R11 watchdog released", {7'd0, core_rst}, 8'h00);
        step(1);
        chk("R7 watchdog flag", rdata, exp_flag);
    endtask

    task automatic t_priority;
        clk_lost = 1'b1;
        wdt      = 1'b1;
        step(2);
        clk_lost = 1'b0;
        wdt      = 1'b0;
        step(3);
        chk("R8 clock loss beats watchdog", rdata, 8'h04);
        ext_n    = 1'b0;
        clk_lost = 1'b1;
        step(2);
        ext_n    = 1'b1;
        clk_lost = 1'b0;
        step(15);
        chk("R8 pin beats clock loss", rdata, 8'h01);
    endtask

    task automatic t_enable_keep;
        write_en(8'h20);
        t_wdt(8'h08);
        cmp = 1'b0;
        #0.5;
        chk("R9 enable kept over watchdog reset", {7'd0, core_rst}, 8'h01);
        step(2);
        cmp = 1'b1;
        step(3);
        chk("R9 comparator flag after kept enable", rdata, 8'h20);
        t_power_on;
        cmp = 1'b0;
        step(3);
        chk("R9 enable cleared by power-on", {7'd0, core_rst}, 8'h00);
        cmp = 1'b1;
        step(1);
    endtask

    task automatic t_readonly;
        write_en(8'h20);
        write_en(8'h9F);
        step(1);
        chk("R10 read-only bits ignore write", rdata, 8'h02);
        cmp = 1'b0;
        step(3);
        chk("R10 writing 0 disables comparator", {7'd0, core_rst}, 8'h00);
        cmp = 1'b1;
        step(1);
        chk("R10 bits 4 and 7 read zero", rdata & 8'h90, 8'h00);
    endtask

    initial begin
        #1;
        t_power_on;
        t_cmp_disabled(8'h02);
        t_pin;
        t_clk_loss;
        t_cmp;
        t_cnv;
        t_wdt(8'h08);
        t_priority;
        t_enable_keep;
        t_readonly;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule